// File: doc/BRIEF.md
# Ratio-Locked Bus Clock Divider

The block turns one master clock into three synchronous clock enables, one for the processor domain, one for the high-throughput interconnect (AXI) and one for the peripheral bus (AHB/APB). Each enable divides the master rate by 1, 2, 4 or 8. A single 6-bit configuration register holds a 2-bit ratio code per domain. Clock gating cells downstream use these enables to build the actual domain clocks. For example, the codes 0, 1 and 2 with an 80 MHz master clock give 80 MHz, 40 MHz and 20 MHz domains.

All three enables are derived from one free-running 3-bit phase counter. As a result, every edge of a slower domain coincides with an edge of each faster domain, and once per eight master cycles all three enables are high together. A write goes into the configuration register at once and can be read back. The dividers pick up new codes only at the counter wrap, so a ratio change never produces a truncated period. The peripheral-bus domain may not run at the full master rate, so a code of divide-by-1 written to that field is stored as divide-by-2.

Top module: `bus_ratio_div`

## Requirements
- R1: After reset the register reads 0x3F and all three enables run at divide by 8: they are high together in the first cycle after reset release and then every eighth cycle.
- R2: Register bits [1:0] set the processor ratio (lane_en[0]), bits [3:2] the interconnect ratio (lane_en[1]) and bits [5:4] the peripheral-bus ratio (lane_en[2]).
- R3: A field code c (00, 01, 10, 11) selects divide by 2^c (1, 2, 4, 8). The lane's enable is high exactly in the cycles where the phase count, taken modulo 2^c, is zero. The phase count is the number of clock edges since reset release, modulo 8.
- R4: A write whose bits [5:4] are 00 stores 01 in that field, and the other fields are stored unchanged. Bits [5:4] never read 00.
- R5: In the cycle where the phase count is zero all enables are high. Whenever a lane with a larger ratio is enabled, every lane with an equal or smaller ratio is enabled too.
- R6: With wr_en high at a clock edge, cfg_rdata shows the stored (legalized) value from the next cycle. Without wr_en it holds its value.
- R7: A new ratio takes effect only from the cycle where the phase count returns to zero. Until then every lane keeps its previous ratio.
- R8: Codes 00 in the processor and interconnect fields are legal and make those enables high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 6 | Value written to the ratio register |
| cfg_rdata | output | 6 | Stored ratio register value |
| lane_en | output | 3 | Clock enables: [0] processor, [1] interconnect, [2] peripheral bus |

## Verification
The enables depend only on the registered phase count and the registered active ratios, so the enable for a phase count is due in that same cycle. The register read-back is due one cycle after the write edge. A write affects the enables only from the first cycle where the phase count is zero after the stored value has changed. The bench runs a cycle-level model of the phase count, stored value and active ratio that updates on the rising edge. It compares every output on the falling edge, across a sweep of all 64 write values issued at varying counter phases. Directed checks cover reset, legalization, divide by 1 and a mid-period ratio change.

// File: rtl/bus_ratio_div_pkg.sv
package bus_ratio_div_pkg;

    // Lane roles, index into the enable vector and the register fields
    typedef enum int unsigned {
        LANE_CPU = 0,
        LANE_XBAR = 1,
        LANE_PBUS = 2
    } lane_id_e;

    localparam int unsigned DEF_LANES   = 3;
    localparam int unsigned DEF_FIELD_W = 2;
    localparam int unsigned DEF_FLOOR   = 32'(LANE_PBUS);

    // Mask of phase bits that must be zero for an enable at code c
    function automatic int unsigned ratio_mask(input int unsigned code);
        return (32'd1 << code) - 32'd1;
    endfunction

endpackage

// File: rtl/ratio_cfg_reg.sv
module ratio_cfg_reg
    import bus_ratio_div_pkg::*;
#(
    parameter int unsigned LANES      = DEF_LANES,
    parameter int unsigned FIELD_W    = DEF_FIELD_W,
    parameter int unsigned FLOOR_LANE = DEF_FLOOR,
    localparam int unsigned REG_W     = LANES * FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cfg_o
);

    typedef struct packed {
        logic [REG_W-1:0] cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic [REG_W-1:0] legal_w;

    // Field legalization: the floor lane may not take code zero
    always_comb begin
        legal_w = wr_data;
        for (int l = 0; l < LANES; l++) begin
            if (l == FLOOR_LANE && wr_data[l*FIELD_W +: FIELD_W] == '0) begin
                legal_w[l*FIELD_W +: FIELD_W] = FIELD_W'(1);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = legal_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

    AST_FLOOR_NOT_DIV1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[FLOOR_LANE*FIELD_W +: FIELD_W] != '0); // R4

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_o)); // R6

endmodule

// File: rtl/ratio_phase_ctr.sv
module ratio_phase_ctr #(
    parameter int unsigned CTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CTR_W-1:0] phase_o,
    output logic             last_o,
    output logic             zero_o
);

    typedef struct packed {
        logic [CTR_W-1:0] phase;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + CTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign last_o  = (st_q.phase == '1);
    assign zero_o  = (st_q.phase == '0);

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> zero_o); // R7

endmodule

// File: rtl/ratio_lane_gen.sv
module ratio_lane_gen
    import bus_ratio_div_pkg::*;
#(
    parameter int unsigned LANES   = DEF_LANES,
    parameter int unsigned FIELD_W = DEF_FIELD_W,
    localparam int unsigned CTR_W  = (1 << FIELD_W) - 1,
    localparam int unsigned REG_W  = LANES * FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTR_W-1:0] phase_i,
    input  logic             last_i,
    input  logic [REG_W-1:0] cfg_i,
    output logic [LANES-1:0] en_o
);

    typedef struct packed {
        logic [REG_W-1:0] act;
    } lane_state_t;

    lane_state_t st_d, st_q;

    // Active ratios are reloaded only on the last phase of a period
    always_comb begin
        st_d = st_q;
        if (last_i) begin
            st_d.act = cfg_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [FIELD_W-1:0] code_w;
        logic [CTR_W-1:0]   mask_w;
        assign code_w  = st_q.act[g*FIELD_W +: FIELD_W];
        assign mask_w  = CTR_W'(ratio_mask(32'(code_w)));
        assign en_o[g] = ((phase_i & mask_w) == '0);
    end

    AST_ACTIVE_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(st_q.act)); // R7

    for (genvar i = 0; i < LANES; i++) begin : g_nest_i
        for (genvar j = 0; j < LANES; j++) begin : g_nest_j
            if (i != j) begin : g_pair
                AST_SLOW_IMPLIES_FAST: assert property (@(posedge clk) disable iff (!rst_n)
                    (st_q.act[i*FIELD_W +: FIELD_W] <= st_q.act[j*FIELD_W +: FIELD_W]) && en_o[j]
                    |-> en_o[i]); // R5
            end
        end
    end

endmodule

// File: rtl/bus_ratio_div.sv
module bus_ratio_div
    import bus_ratio_div_pkg::*;
#(
    parameter int unsigned LANES      = DEF_LANES,
    parameter int unsigned FIELD_W    = DEF_FIELD_W,
    parameter int unsigned FLOOR_LANE = DEF_FLOOR,
    localparam int unsigned CTR_W     = (1 << FIELD_W) - 1,
    localparam int unsigned REG_W     = LANES * FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [LANES-1:0] lane_en
);

    logic [REG_W-1:0] cfg_w;
    logic [CTR_W-1:0] phase_w;
    logic             last_w;
    logic             zero_w;

    ratio_cfg_reg #(
        .LANES      (LANES),
        .FIELD_W    (FIELD_W),
        .FLOOR_LANE (FLOOR_LANE)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_o   (cfg_w)
    );

    ratio_phase_ctr #(
        .CTR_W (CTR_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase_w),
        .last_o  (last_w),
        .zero_o  (zero_w)
    );

    ratio_lane_gen #(
        .LANES   (LANES),
        .FIELD_W (FIELD_W)
    ) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase_w),
        .last_i  (last_w),
        .cfg_i   (cfg_w),
        .en_o    (lane_en)
    );

    assign cfg_rdata = cfg_w;

    AST_ALL_ON_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zero_w |-> (&lane_en)); // R5

endmodule

// File: tb/bus_ratio_div_tb.sv
module bus_ratio_div_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic [5:0] cfg_rdata;
    logic [2:0] lane_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit sweep_on = 1'b0;

    // Reference state built from the requirements
    logic [2:0] m_ctr;
    logic [5:0] m_cfg;
    logic [5:0] m_act;

    bus_ratio_div u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cfg_rdata (cfg_rdata),
        .lane_en   (lane_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] legal(input logic [5:0] v);
        logic [5:0] r;
        r = v;
        if (v[5:4] == 2'b00) r[5:4] = 2'b01;
        return r;
    endfunction

    function automatic logic [2:0] exp_en(input logic [2:0] ph, input logic [5:0] act);
        logic [2:0] e;
        for (int l = 0; l < 3; l++) begin
            int unsigned c;
            c = act[l*2 +: 2];
            e[l] = ((int'(ph) % (1 << c)) == 0);
        end
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctr <= 3'd0;
            m_cfg <= 6'h3F;
            m_act <= 6'h3F;
        end else begin
            m_ctr <= m_ctr + 3'd1;
            if (m_ctr == 3'd7) m_act <= m_cfg;
            if (wr_en) m_cfg <= legal(wr_data);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison during the sweep
    always @(negedge clk) begin
        if (rst_n && sweep_on && !done) begin
            chk("R3 R7 lane enables", 32'(lane_en), 32'(exp_en(m_ctr, m_act)));
            chk("R6 readback", 32'(cfg_rdata), 32'(m_cfg));
            if (m_ctr == 3'd0) chk("R5 all lanes at phase zero", 32'(lane_en), 32'h7);
        end
    end

    task automatic wr(input logic [5:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset value, all lanes divide by 8
        chk("R1 reset readback", 32'(cfg_rdata), 32'h3F);
        chk("R1 all on first cycle", 32'(lane_en), 32'h7);
        for (int k = 1; k < 8; k++) begin
            @(negedge clk);
            chk("R1 idle between divide-by-8 edges", 32'(lane_en), 32'h0);
        end
        @(negedge clk);
        chk("R1 all on eighth cycle", 32'(lane_en), 32'h7);

        // R4: peripheral field 00 stored as 01, others kept
        wr(6'h0B);
        chk("R4 legalized store", 32'(cfg_rdata), 32'h1B);
        wr(6'h00);
        chk("R4 floor field never 00", 32'(cfg_rdata[5:4]), 32'h1);
        chk("R4 other fields kept", 32'(cfg_rdata[3:0]), 32'h0);

        // R2 R8: codes 0,1,2 after the wrap give 1/2/4 pattern
        wr(6'h24);
        chk("R6 readback after write", 32'(cfg_rdata), 32'h24);
        while (m_ctr != 3'd0) @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            chk("R8 cpu lane every cycle", 32'(lane_en[0]), 32'h1);
            chk("R2 xbar lane divide by 2", 32'(lane_en[1]), 32'(((m_ctr % 2) == 0)));
            chk("R2 pbus lane divide by 4", 32'(lane_en[2]), 32'(((m_ctr % 4) == 0)));
            @(negedge clk);
        end

        // R7: return to divide-by-8, then change mid-period
        wr(6'h3F);
        while (m_ctr != 3'd1) @(negedge clk);
        @(negedge clk);
        while (m_ctr != 3'd2) @(negedge clk);
        wr(6'h00);
        while (m_ctr != 3'd0) begin
            chk("R7 old divide-by-8 held before wrap", 32'(lane_en), 32'h0);
            @(negedge clk);
        end
        chk("R7 all on at wrap", 32'(lane_en), 32'h7);
        @(negedge clk);
        chk("R7 new ratios after wrap", 32'(lane_en), 32'h3);

        // Sweep of every write value at varying phases
        sweep_on = 1'b1;
        for (int v = 0; v < 64; v++) begin
            for (int w = 0; w < (v % 5); w++) @(negedge clk);
            wr(6'(v));
            repeat (20) @(negedge clk);
        end
        sweep_on = 1'b0;

        // R1: reset again restores defaults
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 readback after second reset", 32'(cfg_rdata), 32'h3F);
        chk("R1 enables after second reset", 32'(lane_en), 32'h7);
        @(negedge clk);
        chk("R1 divide by 8 after second reset", 32'(lane_en), 32'h0);

        finish_run();
    end

endmodule